// File: doc/BRIEF.md
# Interrupt Vector Resolver with Promotion

This block turns a set of pending interrupt requests into the single vector address a CPU should fetch next. Each maskable source owns a fixed 16-bit vector in the top page of the address space. Source 0 is the general external interrupt at 0xFFF2. Source i sits at 0xFFF2 minus 2*i. A non-maskable request line and a reset-vector request are also resolved. They use 0xFFF4 and 0xFFFE.

Among the maskable sources, a higher vector address normally wins. Software can promote any one maskable source above the others. It does this by writing that source's vector low byte into a promotion register. Writes take effect only while the CPU's interrupt mask is set. Any value that names no implemented maskable vector leaves source 0 on top.

Requests are captured in a register stage and arbitrated combinationally. The winner is registered, so the vector stays steady for the fetch. A separate wake-up output is formed purely from the raw inputs. It works while the clock is stopped in a low-power mode. The parameter `PROMOTE_EN` set to 0 builds a variant without promotion, in which the register is fixed at 0xF2.

Top module: `vec_resolver`

## Requirements
- R1: After reset, `reg_rdata` reads 0xF2, `vec_valid` is 0 and `vec_out` is 0x0000.
- R2: `reg_rdata` shows the stored promotion value, with bit 0 always 0. A write stores `reg_wdata[7:1]` into bits 7:1.
- R3: A write (`reg_wr`=1) while `i_mask`=0 is ignored, and `reg_rdata` keeps its previous value.
- R4: If the promotion value matches no implemented maskable vector low byte (0xF2 - 2*i for i < N_SRC), source 0 (0xFFF2) is treated as promoted. This covers any value above 0xF2.
- R5: Without promotion, the pending maskable source with the lowest index wins, which is the highest address. Its vector is {0xFF, 0xF2 - 2*i}.
- R6: A pending maskable source whose low byte equals the promotion value wins over every other maskable source.
- R7: While `i_mask`=1, maskable requests are not eligible.
- R8: A non-maskable request (`xirq_req`) with `x_mask`=0 yields 0xFFF4 and beats every maskable source. With `x_mask`=1 it is not eligible.
- R9: A reset-vector request (`rstv_req`) yields 0xFFFE and beats everything, whatever the masks.
- R10: Inputs held before clock edge k are reflected on `vec_out`/`vec_valid` after edge k+1. With nothing eligible, `vec_valid`=0 and `vec_out`=0x0000.
- R11: `wake_req` is combinational and needs no clock. It is 1 when any maskable request is present with `i_mask`=0, or when `xirq_req` is high regardless of `x_mask`, or when `rstv_req` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | N_SRC | Maskable request lines, index 0 = 0xFFF2 |
| xirq_req | input | 1 | Non-maskable request |
| rstv_req | input | 1 | Reset vector request |
| i_mask | input | 1 | CPU maskable interrupt mask |
| x_mask | input | 1 | CPU non-maskable interrupt mask |
| reg_wr | input | 1 | Promotion register write strobe |
| reg_wdata | input | 7 | Write data, bits 7:1 of the promotion value |
| reg_rdata | output | 8 | Promotion register read data |
| vec_out | output | 16 | Resolved vector address |
| vec_valid | output | 1 | An eligible request is pending |
| wake_req | output | 1 | Clock-free wake-up request |

## Verification
The checks assume every input is synchronous to `clk`. They also assume each request, mask and write strobe is held across at least one capturing edge. The two-cycle properties only hold when nothing disturbs the input stage in between, apart from a reset, which disables them.

The stimulus changes every input at the falling edge and holds it for a full cycle. The wake-up output is only examined after the clock has been parked low, so its clock-free path is tested on its own.

// File: rtl/vecres_pkg.sv
package vecres_pkg;
   localparam logic [7:0] VEC_PAGE = 8'hFF;
   localparam logic [7:0] IRQ_LOW  = 8'hF2;
   localparam logic [7:0] XIRQ_LOW = 8'hF4;
   localparam logic [7:0] RSTV_LOW = 8'hFE;

   typedef struct packed {
      logic       valid;
      logic [7:0] low;
   } pick_t;

   // Low address byte of maskable source idx.
   function automatic logic [7:0] src_low(input int idx);
      src_low = 8'(int'(IRQ_LOW) - 2 * idx);
   endfunction
endpackage

// File: rtl/vecres_inreg.sv
module vecres_inreg #(
   parameter int N_SRC = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] irq_req,
   input  logic             xirq_req,
   input  logic             rstv_req,
   input  logic             i_mask,
   input  logic             x_mask,
   output logic [N_SRC-1:0] irq_q,
   output logic             xirq_q,
   output logic             rstv_q,
   output logic             imask_q,
   output logic             xmask_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q   <= '0;
         xirq_q  <= 1'b0;
         rstv_q  <= 1'b0;
         imask_q <= 1'b1;
         xmask_q <= 1'b1;
      end else begin
         irq_q   <= irq_req;
         xirq_q  <= xirq_req;
         rstv_q  <= rstv_req;
         imask_q <= i_mask;
         xmask_q <= x_mask;
      end
   end
endmodule

// File: rtl/vecres_prio.sv
module vecres_prio
   import vecres_pkg::*;
#(
   parameter int N_SRC      = 16,
   parameter bit PROMOTE_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [7:1]       wdata,
   input  logic             i_mask,
   output logic [7:0]       rdata,
   output logic [N_SRC-1:0] prom_oh
);
   localparam logic [6:0] RST_STOR = IRQ_LOW[7:1];

   logic [6:0]       stor;
   logic [N_SRC-1:0] match;

   generate
      if (PROMOTE_EN) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             stor <= RST_STOR;
            else if (wr && i_mask)  stor <= wdata;
         end
      end else begin : g_fixed
         assign stor = RST_STOR;
      end
   endgenerate

   assign rdata = {stor, 1'b0};

   // One comparator per source against its fixed vector byte.
   for (genvar i = 0; i < N_SRC; i++) begin : g_dec
      localparam logic [7:0] LOW = src_low(i);
      assign match[i] = (stor == LOW[7:1]);
   end

   always_comb begin
      prom_oh = match;
      if (match == '0) prom_oh[0] = 1'b1;
   end
endmodule

// File: rtl/vecres_arb.sv
module vecres_arb
   import vecres_pkg::*;
#(
   parameter int N_SRC = 16
) (
   input  logic [N_SRC-1:0] irq_q,
   input  logic             xirq_q,
   input  logic             rstv_q,
   input  logic             imask_q,
   input  logic             xmask_q,
   input  logic [N_SRC-1:0] prom_oh,
   output pick_t            pick
);
   logic [7:0] lows [N_SRC];

   for (genvar i = 0; i < N_SRC; i++) begin : g_low
      assign lows[i] = src_low(i);
   end

   logic       m_hit, p_hit;
   logic [7:0] m_low, p_low;

   always_comb begin
      m_hit = 1'b0;
      m_low = 8'h00;
      p_hit = 1'b0;
      p_low = 8'h00;
      for (int i = N_SRC - 1; i >= 0; i--) begin
         if (irq_q[i]) begin
            m_hit = 1'b1;
            m_low = lows[i];
         end
         if (irq_q[i] && prom_oh[i]) begin
            p_hit = 1'b1;
            p_low = lows[i];
         end
      end
   end

   always_comb begin
      pick = '{valid: 1'b0, low: 8'h00};
      if (rstv_q)                      pick = '{valid: 1'b1, low: RSTV_LOW};
      else if (xirq_q && !xmask_q)     pick = '{valid: 1'b1, low: XIRQ_LOW};
      else if (!imask_q && p_hit)      pick = '{valid: 1'b1, low: p_low};
      else if (!imask_q && m_hit)      pick = '{valid: 1'b1, low: m_low};
   end
endmodule

// File: rtl/vec_resolver.sv
module vec_resolver
   import vecres_pkg::*;
#(
   parameter int N_SRC      = 16,
   parameter bit PROMOTE_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] irq_req,
   input  logic             xirq_req,
   input  logic             rstv_req,
   input  logic             i_mask,
   input  logic             x_mask,
   input  logic             reg_wr,
   input  logic [7:1]       reg_wdata,
   output logic [7:0]       reg_rdata,
   output logic [15:0]      vec_out,
   output logic             vec_valid,
   output logic             wake_req
);
   generate
      if (N_SRC < 1 || N_SRC > 64) begin : g_bad_nsrc
         $error("vec_resolver: N_SRC must lie in 1..64");
      end
   endgenerate

   logic [N_SRC-1:0] irq_q, prom_oh;
   logic             xirq_q, rstv_q, imask_q, xmask_q;
   pick_t            pick;

   vecres_inreg #(.N_SRC(N_SRC)) inreg_i (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .xirq_req(xirq_req),
      .rstv_req(rstv_req), .i_mask(i_mask), .x_mask(x_mask),
      .irq_q(irq_q), .xirq_q(xirq_q), .rstv_q(rstv_q),
      .imask_q(imask_q), .xmask_q(xmask_q)
   );

   vecres_prio #(.N_SRC(N_SRC), .PROMOTE_EN(PROMOTE_EN)) prio_i (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata),
      .i_mask(i_mask), .rdata(reg_rdata), .prom_oh(prom_oh)
   );

   vecres_arb #(.N_SRC(N_SRC)) arb_i (
      .irq_q(irq_q), .xirq_q(xirq_q), .rstv_q(rstv_q),
      .imask_q(imask_q), .xmask_q(xmask_q), .prom_oh(prom_oh), .pick(pick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_out   <= 16'h0000;
         vec_valid <= 1'b0;
      end else begin
         vec_valid <= pick.valid;
         vec_out   <= pick.valid ? {VEC_PAGE, pick.low} : 16'h0000;
      end
   end

   // Clock-free wake path straight from the pins.
   assign wake_req = rstv_req | xirq_req | ((|irq_req) & ~i_mask);
endmodule

// File: rtl/vecres_chk.sv
module vecres_chk #(
   parameter int N_SRC = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N_SRC-1:0] irq_req,
   input logic             xirq_req,
   input logic             rstv_req,
   input logic             i_mask,
   input logic             x_mask,
   input logic             reg_wr,
   input logic [7:0]       reg_rdata,
   input logic [15:0]      vec_out,
   input logic             vec_valid,
   input logic             wake_req
);
   p_bit0_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[0] == 1'b0);

   p_wr_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !i_mask) |=> $stable(reg_rdata));

   p_page_r5: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> vec_out[15:8] == 8'hFF);

   p_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!rstv_req && (!xirq_req || x_mask) && i_mask) |=> ##1 !vec_valid);

   p_xirq_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!rstv_req && xirq_req && !x_mask) |=> ##1 (vec_valid && vec_out == 16'hFFF4));

   p_rstv_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rstv_req |=> ##1 (vec_valid && vec_out == 16'hFFFE));

   p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !vec_valid |-> vec_out == 16'h0000);

   p_wake_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (xirq_req || ((|irq_req) && !i_mask)) |-> wake_req);
endmodule

bind vec_resolver vecres_chk #(.N_SRC(N_SRC)) chk_i (.*);

// File: tb/vec_resolver_tb_top.sv
module vec_resolver_tb_top;
   localparam int N = 16;

   logic          clk = 1'b0, clk_run = 1'b1, rst_n = 1'b0;
   logic [N-1:0]  irq_req = '0;
   logic          xirq_req = 0, rstv_req = 0, i_mask = 1, x_mask = 1, reg_wr = 0;
   logic [7:1]    reg_wdata = '0;
   logic [7:0]    reg_rdata;
   logic [15:0]   vec_out;
   logic          vec_valid, wake_req;

   int checks = 0, errors = 0, cyc = 0;
   bit done = 0;
   logic [7:0] mprio = 8'hF2;

   typedef struct {
      int          due;
      logic        v;
      logic [15:0] vec;
      string       tag;
   } exp_t;
   exp_t q[$];

   vec_resolver #(.N_SRC(N)) dut_i (.*);

   always #4 if (clk_run) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [16:0] model(input logic [N-1:0] r, input logic xi, rv, im, xm);
      int idx = 0, w = 0;
      for (int i = 0; i < N; i++)
         if (8'(242 - 2 * i) == {mprio[7:1], 1'b0}) idx = i;
      if (rv) return {1'b1, 16'hFFFE};
      if (xi && !xm) return {1'b1, 16'hFFF4};
      if (!im && (|r)) begin
         if (r[idx]) return {1'b1, 8'hFF, 8'(242 - 2 * idx)};
         for (int i = N - 1; i >= 0; i--) if (r[i]) w = i;
         return {1'b1, 8'hFF, 8'(242 - 2 * w)};
      end
      return 17'h0;
   endfunction

   // Driver: apply one input pattern for one cycle, queue its expected result.
   task automatic drive(input logic [N-1:0] r, input logic xi, rv, im, xm, input string tag);
      logic [16:0] e;
      @(negedge clk);
      irq_req = r; xirq_req = xi; rstv_req = rv; i_mask = im; x_mask = xm;
      e = model(r, xi, rv, im, xm);
      q.push_back('{cyc + 2, e[16], e[15:0], tag});
   endtask

   task automatic wr(input logic im, input logic [7:0] d, input string tag);
      @(negedge clk);
      reg_wr = 1; reg_wdata = d[7:1]; i_mask = im;
      if (im) mprio = {d[7:1], 1'b0};
      @(negedge clk);
      reg_wr = 0;
      check(tag, {8'h00, reg_rdata}, {8'h00, mprio});
   endtask

   // Monitor: pop and compare results when due.
   always @(negedge clk) begin
      while (q.size() > 0 && q[0].due == cyc) begin
         check({q[0].tag, " valid"}, {15'h0, vec_valid}, {15'h0, q[0].v});
         check({q[0].tag, " vec"}, vec_out, q[0].vec);
         void'(q.pop_front());
      end
   end

   task automatic flush();
      repeat (4) @(negedge clk);
      check("R10 queue drained", 16'(q.size()), 16'h0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 8);
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 rdata", {8'h0, reg_rdata}, 16'h00F2);
      check("R1 valid", {15'h0, vec_valid}, 16'h0);
      check("R1 vec", vec_out, 16'h0);
      rst_n = 1;
      // R5 plain ordering
      drive(16'h0008, 0, 0, 0, 1, "R5 single src3");
      drive(16'h0088, 0, 0, 0, 1, "R5 src3+src7");
      drive(16'h8220, 0, 0, 0, 1, "R5 src5+9+15");
      drive(16'h8000, 0, 0, 0, 1, "R5 lowest src15");
      drive(16'h0000, 0, 0, 0, 1, "R10 idle");
      flush();
      // R3 ignored write, R2 accepted write with bit0 dropped
      wr(0, 8'hE0, "R3 write ignored");
      drive(16'h0201, 0, 0, 0, 1, "R3 no promotion after ignored write");
      wr(1, 8'hE1, "R2 write stores bits 7:1");
      drive(16'h0201, 0, 0, 0, 1, "R6 src9 promoted over src0");
      drive(16'h0001, 0, 0, 0, 1, "R6 src0 alone");
      drive(16'h0222, 0, 0, 0, 1, "R6 promoted among several");
      drive(16'hFFFF, 0, 0, 1, 1, "R7 masked");
      drive(16'h0201, 1, 0, 0, 0, "R8 xirq over maskable");
      drive(16'h0201, 1, 0, 0, 1, "R8 xirq masked");
      drive(16'h0201, 1, 1, 1, 0, "R9 reset over xirq");
      drive(16'h0000, 0, 1, 1, 1, "R9 reset with masks set");
      flush();
      // R4 fallback values
      wr(1, 8'hFA, "R4 above range stored");
      drive(16'h0021, 0, 0, 0, 1, "R4 above range falls back");
      drive(16'h0104, 0, 0, 0, 1, "R4 above range no src0");
      wr(1, 8'h10, "R4 below range stored");
      drive(16'h0104, 0, 0, 0, 1, "R4 below range falls back");
      wr(1, 8'hD4, "R2 lowest vector stored");
      drive(16'h8001, 0, 0, 0, 1, "R6 src15 promoted");
      drive(16'h0000, 0, 0, 0, 1, "R10 back to idle");
      flush();
      // R11 wake path with the clock parked low
      @(negedge clk);
      clk_run = 0;
      #20;
      irq_req = 16'h0100; i_mask = 0; x_mask = 1; xirq_req = 0; rstv_req = 0;
      #2 check("R11 maskable wakes", {15'h0, wake_req}, 16'h1);
      i_mask = 1;
      #2 check("R11 masked no wake", {15'h0, wake_req}, 16'h0);
      xirq_req = 1;
      #2 check("R11 xirq wakes despite mask", {15'h0, wake_req}, 16'h1);
      xirq_req = 0; irq_req = '0; rstv_req = 1;
      #2 check("R11 reset request wakes", {15'h0, wake_req}, 16'h1);
      rstv_req = 0;
      #2 check("R11 quiet", {15'h0, wake_req}, 16'h0);
      clk_run = 1;
      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule